// File: doc/BRIEF.md
# Watchdog and Reset Supervisor

This block is a fully synchronous supervisor that produces the system reset for a microcontroller. It combines three reset causes into one reset signal. The first is an active-low manual reset request. The second is a supply-good flag, which replaces the analog voltage comparator. The third is a watchdog that fires when its kick input stops changing. The reset is driven on two complementary outputs, one active-low and one active-high.

Reset is asserted while any level cause is present. Once the last cause goes away, reset stays asserted for a fixed hold time. A watchdog timeout produces one reset pulse of that same hold length. The watchdog counter restarts on every rising or falling edge of the kick input. It is also held at zero while reset is asserted, so software gets a full timeout window after each release.

The manual reset and kick inputs come from outside the clock domain and each passes through a two-stage synchronizer. The supply-good flag is assumed to be synchronous already. The timeout and the hold time are parameters counted in clock cycles.

Top module: `wdt_reset_supervisor`

## Requirements
- R1: While rst_n is low at a clock edge, the block reloads its state and asserts reset. After the last clock edge with rst_n low, reset stays asserted for HOLD_CYC cycles and then deasserts.
- R2: A low level on man_rst_n asserts reset by the third clock edge after the change (two synchronizer stages plus the hold register). Reset stays asserted for as long as man_rst_n is held low.
- R3: When man_rst_n returns high, reset stays asserted for HOLD_CYC cycles after the last clock edge at which the synchronized low was still seen.
- R4: A low supply_ok sampled at a clock edge asserts reset right after that edge. Reset stays asserted for HOLD_CYC cycles after the last edge that sampled supply_ok low.
- R5: If reset is deasserted and no edge on wd_kick is detected for TIMEOUT_CYC consecutive cycles, a reset pulse of exactly HOLD_CYC cycles follows.
- R6: Both a rising and a falling edge of wd_kick restart the watchdog count. The edge takes effect three clock edges after the input changes.
- R7: The watchdog count is held at zero while reset is asserted. The first timeout after any release therefore comes TIMEOUT_CYC cycles after deassertion, whatever wd_kick did during reset.
- R8: A new cause (manual or supply) that arrives during a hold interval restarts the full HOLD_CYC hold. The new hold is counted from the end of that cause.
- R9: sys_rst is always the logical complement of sys_rst_n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous power-on reset, active low |
| man_rst_n | input | 1 | Manual reset request, active low, asynchronous |
| wd_kick | input | 1 | Watchdog kick; any transition restarts the timeout |
| supply_ok | input | 1 | Supply-good flag, synchronous, high when the supply is valid |
| sys_rst_n | output | 1 | System reset, active low |
| sys_rst | output | 1 | System reset, active high |

## Verification
The embedded properties check every cycle that:
- a sampled cause reloads the full hold;
- a supply drop asserts reset on the next edge;
- the watchdog count sits at zero during reset and after each detected kick edge;
- an expiry turns into a full-length reset pulse.

Exact pulse lengths can only be shown by the bench scenarios. These cover:
- the HOLD_CYC tail after each kind of cause;
- the TIMEOUT_CYC gap after a release despite a long idle kick during reset;
- the extra synchronizer latency for manual and kick inputs;
- the restart of the hold when a cause reappears inside it.

A behavioural model compared on every clock also catches any stray cycle of difference.

// File: rtl/wdt_reset_supervisor.sv
module wdt_reset_supervisor #(
  parameter int unsigned TIMEOUT_CYC = 1600,
  parameter int unsigned HOLD_CYC    = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic man_rst_n,
  input  logic wd_kick,
  input  logic supply_ok,
  output logic sys_rst_n,
  output logic sys_rst
);

  localparam int WW = $clog2(TIMEOUT_CYC + 1);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [WW-1:0] W_LAST = WW'(TIMEOUT_CYC - 1);
  localparam logic [HW-1:0] H_LOAD = HW'(HOLD_CYC);

  logic [1:0]    mr_sync;
  logic [2:0]    kick_sync;
  logic [HW-1:0] hold_cnt;
  logic [WW-1:0] wd_cnt;
  logic          in_rst, cause, kick_edge, wd_expire;

  assign in_rst    = (hold_cnt != '0);
  assign cause     = !mr_sync[1] || !supply_ok;
  assign kick_edge = kick_sync[1] ^ kick_sync[2];
  assign wd_expire = !in_rst && !kick_edge && (wd_cnt == W_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mr_sync   <= 2'b11;
      kick_sync <= '0;
      hold_cnt  <= H_LOAD;
      wd_cnt    <= '0;
    end else begin
      mr_sync   <= {mr_sync[0], man_rst_n};
      kick_sync <= {kick_sync[1:0], wd_kick};
      if (cause || wd_expire)
        hold_cnt <= H_LOAD;
      else if (in_rst)
        hold_cnt <= hold_cnt - 1'b1;
      if (in_rst || kick_edge || wd_expire)
        wd_cnt <= '0;
      else
        wd_cnt <= wd_cnt + 1'b1;
    end
  end

  assign sys_rst   = in_rst;
  assign sys_rst_n = !in_rst;

  p_cause_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cause |=> (hold_cnt == H_LOAD));

  p_manual_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mr_sync[1] |=> sys_rst);

  p_supply_assert_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (sys_rst && !sys_rst_n));

  p_wd_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_rst |=> (wd_cnt == '0));

  p_edge_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    kick_edge |=> (wd_cnt == '0));

  p_expire_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> (sys_rst && hold_cnt == H_LOAD));

endmodule

// File: tb/wdt_reset_supervisor_tb.sv
module wdt_reset_supervisor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int T = 40;
  localparam int H = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic man_rst_n = 1;
  logic wd_kick = 0;
  logic supply_ok = 1;
  logic sys_rst_n, sys_rst;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string phase = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_reset_supervisor #(.TIMEOUT_CYC(T), .HOLD_CYC(H)) u_dut (
    .clk(clk), .rst_n(rst_n), .man_rst_n(man_rst_n), .wd_kick(wd_kick),
    .supply_ok(supply_ok), .sys_rst_n(sys_rst_n), .sys_rst(sys_rst));

  // behavioural reference: delayed input histories and two integer timers
  bit mr_hist[2];
  bit kick_hist[3];
  int m_hold = H;
  int m_age = 0;
  bit exp_rst = 1;
  bit m_in, m_cause, m_edge, m_exp;

  always @(posedge clk) begin
    if (!rst_n) begin
      mr_hist = '{1, 1};
      kick_hist = '{0, 0, 0};
      m_hold = H;
      m_age = 0;
    end else begin
      m_in = m_hold > 0;
      m_cause = !mr_hist[1] || !supply_ok;
      m_edge = kick_hist[1] != kick_hist[2];
      m_exp = !m_in && !m_edge && m_age == T - 1;
      if (m_cause || m_exp) m_hold = H;
      else if (m_in) m_hold = m_hold - 1;
      if (m_in || m_edge || m_exp) m_age = 0;
      else m_age = m_age + 1;
      mr_hist[1] = mr_hist[0];
      mr_hist[0] = man_rst_n;
      kick_hist[2] = kick_hist[1];
      kick_hist[1] = kick_hist[0];
      kick_hist[0] = wd_kick;
    end
    exp_rst = m_hold > 0;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(sys_rst == exp_rst, {phase, " model"}, sys_rst, exp_rst);
      check(sys_rst == !sys_rst_n, "R9 complement", sys_rst, !sys_rst_n);
    end
  end

  task automatic measure(input bit level, output int n);
    n = 0;
    while (sys_rst == level && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(sys_rst == 1 && sys_rst_n == 0, "R1 reset state", sys_rst, 1);
    rst_n = 1;
    @(negedge clk);
    measure(1, n); check(n == H - 1, "R1 power-on hold", n, H - 1);

    phase = "R5";
    measure(0, n); check(n == T, "R5 timeout gap", n, T);
    measure(1, n); check(n == H, "R5 pulse length", n, H);

    phase = "R6";
    for (int i = 0; i < 20; i++) begin
      wd_kick = ~wd_kick;
      repeat (10) @(negedge clk);
      if (sys_rst) check(0, "R6 kick keeps reset off", 1, 0);
    end
    check(sys_rst == 0, "R6 toggling kick", sys_rst, 0);
    wd_kick = 1;
    repeat (10) @(negedge clk);
    wd_kick = 0;
    @(negedge clk);
    measure(0, n); check(n == T + 2, "R6 falling edge restart", n, T + 2);
    measure(1, n); check(n == H, "R6 pulse after fall", n, H);
    repeat (10) @(negedge clk);
    wd_kick = 1;
    @(negedge clk);
    measure(0, n); check(n == T + 2, "R6 rising edge restart", n, T + 2);
    measure(1, n); check(n == H, "R6 pulse after rise", n, H);

    phase = "R2";
    man_rst_n = 0;
    @(negedge clk); @(negedge clk);
    check(sys_rst == 0, "R2 sync latency", sys_rst, 0);
    @(negedge clk);
    check(sys_rst == 1, "R2 manual asserts", sys_rst, 1);
    n = 0;
    for (int i = 0; i < 3 * T; i++) begin
      @(negedge clk);
      if (!sys_rst) n++;
    end
    check(n == 0, "R2 held while low", n, 0);
    phase = "R3";
    man_rst_n = 1;
    @(negedge clk);
    measure(1, n); check(n == H + 1, "R3 manual release hold", n, H + 1);
    phase = "R7";
    measure(0, n); check(n == T, "R7 watchdog held clear", n, T);
    measure(1, n);

    phase = "R4";
    supply_ok = 0;
    @(negedge clk);
    check(sys_rst == 1, "R4 supply asserts", sys_rst, 1);
    repeat (20) @(negedge clk);
    supply_ok = 1;
    @(negedge clk);
    measure(1, n); check(n == H - 1, "R4 supply hold", n, H - 1);

    phase = "R8";
    supply_ok = 0;
    repeat (5) @(negedge clk);
    supply_ok = 1;
    repeat (3) @(negedge clk);
    supply_ok = 0;
    @(negedge clk);
    supply_ok = 1;
    @(negedge clk);
    measure(1, n); check(n == H - 1, "R8 supply restart", n, H - 1);
    repeat (5) @(negedge clk);
    supply_ok = 0;
    @(negedge clk);
    supply_ok = 1;
    repeat (4) @(negedge clk);
    man_rst_n = 0;
    repeat (4) @(negedge clk);
    man_rst_n = 1;
    @(negedge clk);
    measure(1, n); check(n == H + 1, "R8 manual restart", n, H + 1);
    measure(0, n); check(n == T, "R8 timeout after restart", n, T);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(negedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule